// File: doc/BRIEF.md
# Receive Data-Link Stack Extractor

This block sits behind a DS1 receive framer and its frame aligner. The aligner supplies each payload bit together with its frame, time-slot and bit numbers. From that stream the block picks out the facility data-link bits and gathers them into a two-word stack that the host can read. Two extraction modes are available. The first follows the signalling-frame data link of a 72-frame subscriber-carrier superframe. This mode gathers 24 bits: the eleven concentrator bits, four spoiler bits, three maintenance bits, two alarm bits and four switching bits. The second follows the digital data service link, which takes one bit from the last time slot in each frame of a 12-frame cycle.

Extraction does not depend on any host setting. When the stack has been filled, the new contents are committed as one unit and a stack-ready status bit is set. The host then has one superframe to read both words before the next fill replaces them. A sticky loss-of-frame status bit and a live loss-of-frame view are also provided. A mask register selects which status bits drive the interrupt line. An input pin chooses whether the status bits clear when read or when a one is written to them. Losing the alignment that the active mode needs abandons a partly gathered fill.

Top module: `dlink_rx_stack`

## Requirements
- R1: After reset both stack words, the status bits, the mask and the interrupt output are all zero.
- R2: With `mode_slc_i`=1, a bit is taken only when `slot_num_i`=0 (the framing-bit position) and `frm_num_i` is even. The frame count is 0..71, and the even frames carry the signalling-frame bits. Taking `k = frm_num_i/2`, the values k=0..11 are sync bits and are not stored. The values k=12..35 are the 24 data bits, stored in order of arrival. The first data bit goes to word 0 bit 15 and the 17th to word 1 bit 15. Word 1 bits 7:0 read as zero.
- R3: With `mode_slc_i`=0, a bit is taken only when `slot_num_i`=24 and `bit_num_i`=6, with bits numbered 1..8. The frame count 0..11 stands for frames 1..12. The bit of frame count f goes to word 0 bit 11-f. Word 0 bits 15:12 and all of word 1 read as zero.
- R4: The stack words and status bit 0 (ready) change on the clock edge that takes the last bit of a fill. The stack words keep their value at all other times, including during a partial fill.
- R5: Alignment is required for extraction. In mode R2 this means `bfa_i`=1 and `mfa_i`=1; in mode R3 only `bfa_i`=1 is needed and `mfa_i` is ignored. Any cycle without the required alignment discards the bits gathered so far. A new fill then starts only at data bit 0, and no ready is flagged until that fill is complete.
- R6: The mask has no effect on extraction. A masked ready event still updates the stack and sets status bit 0.
- R7: Status bit 1 is set in every cycle that `lof_i` is high and stays set until it is cleared. Status bit 2 reads the live `lof_i` value.
- R8: With `clr_on_wr_i`=0, a read of the status register returns bits 1:0 and then clears the bits it returned. Writes to the status register have no effect.
- R9: With `clr_on_wr_i`=1, reads do not clear the status bits. A write to the status register clears each bit whose data bit is 1. A set event in the same cycle takes priority over the clear.
- R10: `irq_o` is high when (status bit 0 AND mask bit 0) OR (status bit 1 AND mask bit 1). The mask is the read/write register at address 3, bits 1:0.
- R11: A host read returns data in `hst_rdata_o` on the clock edge after `hst_rd_i` is sampled. Address 0 is stack word 0, address 1 is stack word 1, address 2 is status and address 3 is the mask. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the payload side and the host side |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_vld_i | input | 1 | A payload bit is present this cycle |
| pay_bit_i | input | 1 | Payload bit value |
| frm_num_i | input | 7 | Frame count within the superframe from the aligner |
| slot_num_i | input | 5 | Slot number: 0 framing bit, 1..24 payload slots |
| bit_num_i | input | 4 | Bit number within the slot, 1..8 |
| mode_slc_i | input | 1 | 1: subscriber-carrier link (R2), 0: data-service link (R3) |
| bfa_i | input | 1 | Basic frame alignment established |
| mfa_i | input | 1 | Multiframe alignment established |
| lof_i | input | 1 | Loss-of-frame indication |
| clr_on_wr_i | input | 1 | Status clear policy: 0 clear on read, 1 clear on write |
| hst_rd_i | input | 1 | Host read strobe |
| hst_wr_i | input | 1 | Host write strobe |
| hst_addr_i | input | 2 | Host register address |
| hst_wdata_i | input | 16 | Host write data |
| hst_rdata_o | output | 16 | Registered host read data |
| irq_o | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check the following. Losing alignment resets the write pointer. The stack words hold still unless a fill is finishing. A data-service fill leaves the padding at zero. A finished fill and a loss-of-frame input each set their status bit. Under the clear-on-write policy, the ready bit is not dropped by anything other than a status write. A zero mask keeps the interrupt low. Only the bench scenarios can show the following. Bit order and packing across the two words in each mode. The rejection of bits at neighbouring slot and bit positions. The waiting for data bit 0 after an aborted fill. The exact values seen by clear-on-read and clear-on-write, including a set and a clear in the same cycle.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    typedef enum logic [1:0] {
        REG_WORD0  = 2'd0,
        REG_WORD1  = 2'd1,
        REG_STATUS = 2'd2,
        REG_MASK   = 2'd3
    } reg_sel_e;

    localparam int STS_READY = 0;
    localparam int STS_LOF   = 1;
    localparam int STS_W     = 2;

endpackage

// File: rtl/dlink_tap.sv
module dlink_tap #(
    parameter int FRM_W    = 7,
    parameter int SLOT_W   = 5,
    parameter int BIT_W    = 4,
    parameter int IDX_W    = 5,
    parameter int SLC_SKIP = 12,
    parameter int SLC_LEN  = 24,
    parameter int DDS_LEN  = 12,
    parameter int DDS_SLOT = 24,
    parameter int DDS_BIT  = 6
) (
    input  logic              slc_i,
    input  logic              bfa_i,
    input  logic              mfa_i,
    input  logic              vld_i,
    input  logic [FRM_W-1:0]  frm_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [BIT_W-1:0]  bitn_i,
    output logic              aligned_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [FRM_W-1:0]  SKIP_K = FRM_W'(SLC_SKIP);
    localparam logic [FRM_W-1:0]  END_K  = FRM_W'(SLC_SKIP + SLC_LEN);
    localparam logic [FRM_W-1:0]  DDS_N  = FRM_W'(DDS_LEN);
    localparam logic [SLOT_W-1:0] D_SLOT = SLOT_W'(DDS_SLOT);
    localparam logic [BIT_W-1:0]  D_BIT  = BIT_W'(DDS_BIT);

    logic [FRM_W-1:0] fs_k;
    logic             slc_hit, dds_hit;
    logic [IDX_W-1:0] slc_idx, dds_idx;

    always_comb begin
        fs_k    = frm_i >> 1;
        slc_hit = vld_i && (slot_i == '0) && !frm_i[0] && (fs_k >= SKIP_K) && (fs_k < END_K);
        dds_hit = vld_i && (slot_i == D_SLOT) && (bitn_i == D_BIT) && (frm_i < DDS_N);
        slc_idx = IDX_W'(fs_k - SKIP_K);
        dds_idx = IDX_W'(frm_i);
        aligned_o = bfa_i && (mfa_i || !slc_i);
        hit_o     = slc_i ? slc_hit : dds_hit;
        idx_o     = slc_i ? slc_idx : dds_idx;
    end

endmodule

// File: rtl/dlink_fill.sv
module dlink_fill #(
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 5,
    parameter int SLC_LEN = 24,
    parameter int DDS_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slc_i,
    input  logic              aligned_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic [WORD_W-1:0] w0_o,
    output logic [WORD_W-1:0] w1_o
);
    localparam int SH_W  = (SLC_LEN > DDS_LEN) ? SLC_LEN : DDS_LEN;
    localparam int STK_W = 2 * WORD_W;
    localparam logic [IDX_W-1:0] SLC_LAST = IDX_W'(SLC_LEN - 1);
    localparam logic [IDX_W-1:0] DDS_LAST = IDX_W'(DDS_LEN - 1);
    localparam logic [IDX_W-1:0] MAX_LAST = IDX_W'(SH_W - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  ptr;
        logic              slc;
        logic [SH_W-1:0]   shadow;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } fill_t;

    fill_t            fill_q, fill_d;
    logic [SH_W-1:0]  sh_nx;
    logic [STK_W-1:0] slc_pack;
    logic [IDX_W-1:0] last_idx;
    logic             done;

    always_comb begin
        fill_d     = fill_q;
        fill_d.slc = slc_i;
        done       = 1'b0;
        last_idx   = slc_i ? SLC_LAST : DDS_LAST;
        sh_nx      = (fill_q.ptr == '0) ? SH_W'(bit_i) : {fill_q.shadow[SH_W-2:0], bit_i};
        slc_pack   = STK_W'(sh_nx[SLC_LEN-1:0]) << (STK_W - SLC_LEN);
        if (!aligned_i || (slc_i != fill_q.slc)) begin
            fill_d.ptr    = '0;
            fill_d.shadow = '0;
        end else if (hit_i && (idx_i == fill_q.ptr)) begin
            if (fill_q.ptr == last_idx) begin
                done          = 1'b1;
                fill_d.ptr    = '0;
                fill_d.shadow = '0;
                if (slc_i) begin
                    fill_d.w0 = slc_pack[STK_W-1:WORD_W];
                    fill_d.w1 = slc_pack[WORD_W-1:0];
                end else begin
                    fill_d.w0 = WORD_W'(sh_nx[DDS_LEN-1:0]);
                    fill_d.w1 = '0;
                end
            end else begin
                fill_d.ptr    = fill_q.ptr + 1'b1;
                fill_d.shadow = sh_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign done_o = done;
    assign w0_o   = fill_q.w0;
    assign w1_o   = fill_q.w1;

    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned_i |=> (fill_q.ptr == '0));

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q.ptr <= MAX_LAST);

    assert_stack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(fill_q.w0) && $stable(fill_q.w1)));

    assert_dds_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !slc_i) |=> ((fill_q.w1 == '0) && ((fill_q.w0 >> DDS_LEN) == '0)));

endmodule

// File: rtl/dlink_host.sv
module dlink_host
    import dlink_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              lof_i,
    input  logic              clr_on_wr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] w0_i,
    input  logic [WORD_W-1:0] w1_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [STS_W-1:0]  sts;
        logic [STS_W-1:0]  mask;
        logic [WORD_W-1:0] rdata;
    } host_t;

    host_t            host_q, host_d;
    reg_sel_e         sel;
    logic [STS_W-1:0] set_v, clr_v;
    logic [STS_W:0]   sts_view;
    logic             wdata_unused;

    assign wdata_unused = ^wdata_i[WORD_W-1:STS_W];

    always_comb begin
        host_d   = host_q;
        sel      = reg_sel_e'(addr_i);
        sts_view = {lof_i, host_q.sts};
        set_v            = '0;
        set_v[STS_READY] = done_i;
        set_v[STS_LOF]   = lof_i;
        clr_v = '0;
        if (clr_on_wr_i) begin
            if (wr_i && (sel == REG_STATUS)) clr_v = wdata_i[STS_W-1:0];
        end else if (rd_i && (sel == REG_STATUS)) begin
            clr_v = host_q.sts;
        end
        host_d.sts = (host_q.sts & ~clr_v) | set_v;
        if (wr_i && (sel == REG_MASK)) host_d.mask = wdata_i[STS_W-1:0];
        if (rd_i) begin
            case (sel)
                REG_WORD0:  host_d.rdata = w0_i;
                REG_WORD1:  host_d.rdata = w1_i;
                REG_STATUS: host_d.rdata = WORD_W'(sts_view);
                default:    host_d.rdata = WORD_W'(host_q.mask);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) host_q <= '0;
        else        host_q <= host_d;
    end

    assign rdata_o = host_q.rdata;
    assign irq_o   = |(host_q.sts & host_q.mask);

    assert_ready_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> host_q.sts[STS_READY]);

    assert_lof_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lof_i |=> host_q.sts[STS_LOF]);

    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_q.mask == '0) |-> !irq_o);

    assert_cow_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_wr_i && host_q.sts[STS_READY] && !(wr_i && (sel == REG_STATUS)))
        |=> host_q.sts[STS_READY]);

endmodule

// File: rtl/dlink_rx_stack.sv
module dlink_rx_stack #(
    parameter int WORD_W   = 16,
    parameter int FRM_W    = 7,
    parameter int SLOT_W   = 5,
    parameter int BIT_W    = 4,
    parameter int SLC_SKIP = 12,
    parameter int SLC_LEN  = 24,
    parameter int DDS_LEN  = 12,
    parameter int DDS_SLOT = 24,
    parameter int DDS_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pay_vld_i,
    input  logic              pay_bit_i,
    input  logic [FRM_W-1:0]  frm_num_i,
    input  logic [SLOT_W-1:0] slot_num_i,
    input  logic [BIT_W-1:0]  bit_num_i,
    input  logic              mode_slc_i,
    input  logic              bfa_i,
    input  logic              mfa_i,
    input  logic              lof_i,
    input  logic              clr_on_wr_i,
    input  logic              hst_rd_i,
    input  logic              hst_wr_i,
    input  logic [1:0]        hst_addr_i,
    input  logic [WORD_W-1:0] hst_wdata_i,
    output logic [WORD_W-1:0] hst_rdata_o,
    output logic              irq_o
);
    localparam int SH_W  = (SLC_LEN > DDS_LEN) ? SLC_LEN : DDS_LEN;
    localparam int IDX_W = $clog2(SH_W + 1);

    logic              aligned, hit, done;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] w0, w1;

    dlink_tap #(
        .FRM_W(FRM_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W), .IDX_W(IDX_W),
        .SLC_SKIP(SLC_SKIP), .SLC_LEN(SLC_LEN), .DDS_LEN(DDS_LEN),
        .DDS_SLOT(DDS_SLOT), .DDS_BIT(DDS_BIT)
    ) u_tap (
        .slc_i(mode_slc_i), .bfa_i(bfa_i), .mfa_i(mfa_i), .vld_i(pay_vld_i),
        .frm_i(frm_num_i), .slot_i(slot_num_i), .bitn_i(bit_num_i),
        .aligned_o(aligned), .hit_o(hit), .idx_o(idx)
    );

    dlink_fill #(
        .WORD_W(WORD_W), .IDX_W(IDX_W), .SLC_LEN(SLC_LEN), .DDS_LEN(DDS_LEN)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .slc_i(mode_slc_i), .aligned_i(aligned),
        .hit_i(hit), .idx_i(idx), .bit_i(pay_bit_i),
        .done_o(done), .w0_o(w0), .w1_o(w1)
    );

    dlink_host #(
        .WORD_W(WORD_W)
    ) u_host (
        .clk(clk), .rst_n(rst_n), .done_i(done), .lof_i(lof_i),
        .clr_on_wr_i(clr_on_wr_i), .rd_i(hst_rd_i), .wr_i(hst_wr_i),
        .addr_i(hst_addr_i), .wdata_i(hst_wdata_i), .w0_i(w0), .w1_i(w1),
        .rdata_o(hst_rdata_o), .irq_o(irq_o)
    );

endmodule

// File: tb/tb_dlink_rx_stack.sv
module tb_dlink_rx_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pay_vld = 1'b0, pay_bit = 1'b0;
    logic [6:0]  frm_num = '0;
    logic [4:0]  slot_num = '0;
    logic [3:0]  bit_num = '0;
    logic        mode_slc = 1'b1, bfa = 1'b1, mfa = 1'b1, lof = 1'b0, clr_on_wr = 1'b0;
    logic        hst_rd = 1'b0, hst_wr = 1'b0;
    logic [1:0]  hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic        rd_seen = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dlink_rx_stack dut (
        .clk(clk), .rst_n(rst_n), .pay_vld_i(pay_vld), .pay_bit_i(pay_bit),
        .frm_num_i(frm_num), .slot_num_i(slot_num), .bit_num_i(bit_num),
        .mode_slc_i(mode_slc), .bfa_i(bfa), .mfa_i(mfa), .lof_i(lof),
        .clr_on_wr_i(clr_on_wr), .hst_rd_i(hst_rd), .hst_wr_i(hst_wr),
        .hst_addr_i(hst_addr), .hst_wdata_i(hst_wdata),
        .hst_rdata_o(hst_rdata), .irq_o(irq)
    );

    // monitor: read data is registered one edge after the strobe (R11)
    always @(posedge clk) rd_seen <= hst_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (hst_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected %h", t, hst_rdata, e);
            end
        end
    end

    task automatic hread(input logic [1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        hst_rd = 1'b1; hst_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b", t, irq, e);
        end
    endtask

    task automatic send(input int f, input int s, input int b, input logic v);
        @(negedge clk);
        pay_vld = 1'b1; frm_num = 7'(f); slot_num = 5'(s); bit_num = 4'(b); pay_bit = v;
        @(negedge clk);
        pay_vld = 1'b0;
    endtask

    // one 72-frame superframe; drop_at >= 0 removes multiframe alignment before that frame
    task automatic slc_super(input logic [23:0] dv, input int drop_at);
        for (int f = 0; f < 72; f++) begin
            int k;
            logic v;
            if (f == drop_at) begin
                @(negedge clk); mfa = 1'b0;
                @(negedge clk); mfa = 1'b1;
            end
            k = f / 2;
            if (f % 2 == 1) v = f[1];
            else if (k < 12) v = k[0];
            else v = dv[23 - (k - 12)];
            send(f, 0, 1, v);
            send(f, 24, 6, ~v);
        end
    endtask

    task automatic dds_super(input logic [11:0] dv, input int drop_at);
        for (int f = 0; f < 12; f++) begin
            if (f == drop_at) begin
                @(negedge clk); bfa = 1'b0;
                @(negedge clk); bfa = 1'b1;
            end
            send(f, 24, 5, ~dv[11 - f]);
            send(f, 23, 6, 1'b1);
            send(f, 0, 1, ~dv[11 - f]);
            send(f, 24, 6, dv[11 - f]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_irq(1'b0, "R1 irq");
        hread(2'd0, 16'h0000, "R1 word0");
        hread(2'd1, 16'h0000, "R1 word1");
        hread(2'd2, 16'h0000, "R1 status");
        hread(2'd3, 16'h0000, "R1 mask");

        // R2 packing, R6 masked ready still latches, R8 clear on read
        slc_super(24'hA5C396, -1);
        hread(2'd0, 16'hA5C3, "R2 word0");
        hread(2'd1, 16'h9600, "R2 word1");
        check_irq(1'b0, "R6 masked ready keeps irq low");
        hread(2'd2, 16'h0001, "R6 ready latched while masked");
        hread(2'd2, 16'h0000, "R8 cleared by read");
        hread(2'd0, 16'hA5C3, "R4 stack held after read");

        // R8 write ignored under clear-on-read
        slc_super(24'h123456, -1);
        hwrite(2'd2, 16'h0003);
        hread(2'd2, 16'h0001, "R8 write has no effect");
        hread(2'd2, 16'h0000, "R8 cleared by read");
        hread(2'd0, 16'h1234, "R2 word0 second fill");
        hread(2'd1, 16'h5600, "R2 word1 second fill");

        // R10 interrupt with ready unmasked
        hwrite(2'd3, 16'h0001);
        slc_super(24'h3C0FF1, -1);
        check_irq(1'b1, "R10 ready unmasked");
        hread(2'd3, 16'h0001, "R11 mask readback");
        hread(2'd2, 16'h0001, "R4 ready");
        check_irq(1'b0, "R10 irq drops after clear");

        // R5 multiframe loss aborts a subscriber-carrier fill
        slc_super(24'hFFFFFF, 50);
        hread(2'd2, 16'h0000, "R5 no ready after abort");
        hread(2'd0, 16'h3C0F, "R5 word0 kept");
        hread(2'd1, 16'hF100, "R5 word1 kept");
        slc_super(24'h00FF00, -1);
        hread(2'd0, 16'h00FF, "R5 refill word0");
        hread(2'd1, 16'h0000, "R5 refill word1");
        hread(2'd2, 16'h0001, "R5 refill ready");

        // R3 data-service mode, multiframe alignment ignored
        mode_slc = 1'b0;
        mfa = 1'b0;
        dds_super(12'hB3A, -1);
        hread(2'd0, 16'h0B3A, "R3 word0");
        hread(2'd1, 16'h0000, "R3 word1 zero");
        hread(2'd2, 16'h0001, "R4 ready data-service");
        dds_super(12'h5C5, 6);
        hread(2'd2, 16'h0000, "R5 basic loss aborts");
        hread(2'd0, 16'h0B3A, "R5 data-service word0 kept");
        dds_super(12'h5C5, -1);
        hread(2'd0, 16'h05C5, "R3 word0 refill");
        hread(2'd2, 16'h0001, "R3 ready refill");

        // R7 / R9 loss of frame under clear-on-write
        clr_on_wr = 1'b1;
        hwrite(2'd3, 16'h0002);
        @(negedge clk); lof = 1'b1;
        repeat (3) @(negedge clk);
        lof = 1'b0;
        check_irq(1'b1, "R10 lof unmasked");
        hread(2'd2, 16'h0002, "R7 lof latched");
        hread(2'd2, 16'h0002, "R9 read does not clear");
        hwrite(2'd2, 16'h0002);
        hread(2'd2, 16'h0000, "R9 write clears");
        check_irq(1'b0, "R10 irq cleared");
        @(negedge clk); lof = 1'b1;
        hread(2'd2, 16'h0006, "R7 live lof");
        hwrite(2'd2, 16'h0002);
        hread(2'd2, 16'h0006, "R9 set wins over clear");
        @(negedge clk); lof = 1'b0;
        hwrite(2'd2, 16'h0002);
        hread(2'd2, 16'h0000, "R9 clear after lof gone");

        // R9 ready bit under clear-on-write
        dds_super(12'hFFF, -1);
        hread(2'd2, 16'h0001, "R9 ready set");
        hread(2'd2, 16'h0001, "R9 ready kept after read");
        hwrite(2'd2, 16'h0001);
        hread(2'd2, 16'h0000, "R9 ready cleared by write");
        hread(2'd0, 16'h0FFF, "R3 all ones");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule